// File: doc/BRIEF.md
# Dual-Host Bridge Command Register Block

This block holds the control registers that two hosts use to set up a non-transparent bridge between them. Each host has its own register bank, reached through a simple word-addressed read/write bus. A host loads an argument, a 64-bit target address and a length. It then writes a command word. The bank decodes the command and checks it. If the command is valid, the bank latches the doorbell or memory-window configuration for the translators downstream, with a one-cycle strobe. It reports busy, then success or error, in a status word, and it clears the command word by itself.

The same bank also carries read-only words for the translators' geometry and for the port's role: primary or secondary. After the control words come the doorbell data words and then the host's scratchpad words, all in one aperture. A link handshake keeps one ready flag per host. The block raises a single link event to both hosts only when each host has sent its link command.

Each bank runs a two-state command machine. P_IDLE moves to P_EXEC when a nonzero command word is written. P_EXEC always returns to P_IDLE one cycle later, after it writes the status. The shared link machine moves from L_WAIT to L_UP when both ready flags are set, and it emits the event on that transition. L_UP holds until reset.

Top module: `bridge_cmd_regs`

## Requirements
- R1: Word indices per host are: 0 command, 1 argument, 2 status, 3 topology, 4 address low, 5 address high, 6 size, 7 window-1 byte offset, 8 window count, 9 scratchpad byte offset, 10 scratchpad count, 11 doorbell entry stride. The NUM_DB doorbell data words start at 12, and the SPAD_CNT scratchpad words start at 12+NUM_DB. A read returns its data in the cycle after the read strobe. Unmapped words read 0.
- R2: The read-only words read as follows. Topology is 1 on port 0 and 2 on port 1. The window-1 offset is NUM_DB*DB_STRIDE, the window count is NUM_MW, the scratchpad offset is (12+NUM_DB)*4, the scratchpad count is SPAD_CNT and the stride is DB_STRIDE. Writes to words 2 and 3, and to words 7 through 11, have no effect.
- R3: Writing a nonzero command word while idle makes status read 1 (busy) in the next cycle. One cycle later, status reads 2 (success) or 3 (error) and the command word reads 0. Writing zero to the command word changes nothing.
- R4: Command 1 configures doorbells. Argument bits 15:0 give the count, and bit 16 selects MSI-X (1) or MSI (0). A count from 1 to NUM_DB succeeds: db_cnt and db_msix update, and db_stb pulses for one cycle, in the cycle after the busy cycle.
- R5: Command 2 configures a window. An argument below NUM_MW succeeds: mw_idx takes the argument, mw_addr takes {address high, address low}, mw_size takes the size word, and mw_stb pulses for one cycle, in the cycle after the busy cycle.
- R6: Any other command code fails with an error and leaves all configuration outputs unchanged, without a strobe. So does a doorbell count of 0 or above NUM_DB, and so does a window index at or above NUM_MW.
- R7: Command 3 always succeeds and sets that host's ready flag. link_evt rises on both bits for exactly one cycle, two cycles after the write edge of whichever host's link command completes the pair. It never pulses again until reset.
- R8: The doorbell data words and scratchpad words are read/write, and the two hosts' copies are independent.
- R9: After reset, status and command read 0, every configuration output is 0, and no strobe or link event is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_wr | input | 2 | Write strobe per host |
| h_rd | input | 2 | Read strobe per host |
| h_addr | input | 2 x AW | Word index per host |
| h_wdata | input | 2 x 32 | Write data per host |
| h_rdata | output | 2 x 32 | Read data per host, one cycle after the read strobe |
| db_stb | output | 2 | Doorbell configuration update pulse |
| db_cnt | output | 2 x 16 | Configured doorbell count |
| db_msix | output | 2 | Doorbell interrupt flavour, 1 = MSI-X |
| mw_stb | output | 2 | Window configuration update pulse |
| mw_idx | output | 2 x MW_IW | Configured window index |
| mw_addr | output | 2 x 64 | Window target address |
| mw_size | output | 2 x 32 | Window length |
| link_evt | output | 2 | Link-up event pulse to each host |

## Verification
The bench builds the block with NUM_DB=4, NUM_MW=3, SPAD_CNT=4 and DB_STRIDE=8. With these values, the doorbell-count limits 0 and 5 and the window index 3 are only a step past the legal range, so random stimulus reaches the error boundaries often. The non-power-of-two window count also means an illegal index still fits in the index field. The small scratchpad lets the address map end at word 20, so every unmapped word up to 63 is readable as zero.

// File: rtl/bcr_pkg.sv
package bcr_pkg;

    typedef enum logic {
        P_IDLE = 1'b0,
        P_EXEC = 1'b1
    } port_state_t;

    typedef enum logic {
        L_WAIT = 1'b0,
        L_UP   = 1'b1
    } link_state_t;

    localparam logic [31:0] CMD_DOORBELL = 32'd1;
    localparam logic [31:0] CMD_WINDOW   = 32'd2;
    localparam logic [31:0] CMD_LINK     = 32'd3;

    localparam logic [31:0] STS_IDLE = 32'd0;
    localparam logic [31:0] STS_BUSY = 32'd1;
    localparam logic [31:0] STS_OK   = 32'd2;
    localparam logic [31:0] STS_ERR  = 32'd3;

    localparam logic [31:0] TOPO_PRIMARY   = 32'd1;
    localparam logic [31:0] TOPO_SECONDARY = 32'd2;

    localparam int W_CMD     = 0;
    localparam int W_ARG     = 1;
    localparam int W_STATUS  = 2;
    localparam int W_TOPO    = 3;
    localparam int W_ADDR_LO = 4;
    localparam int W_ADDR_HI = 5;
    localparam int W_SIZE    = 6;
    localparam int W_MW1_OFF = 7;
    localparam int W_MW_NUM  = 8;
    localparam int W_SP_OFF  = 9;
    localparam int W_SP_NUM  = 10;
    localparam int W_DB_STR  = 11;
    localparam int W_DB_BASE = 12;

endpackage

// File: rtl/bcr_link.sv
module bcr_link
    import bcr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] set_req,
    output logic       evt
);

    link_state_t state_q, state_d;
    logic [1:0]  rdy_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            L_WAIT:  if (&rdy_q) state_d = L_UP;
            L_UP:    state_d = L_UP;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= L_WAIT;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdy_q <= '0;
            evt   <= 1'b0;
        end else begin
            rdy_q <= rdy_q | set_req;
            evt   <= (state_q == L_WAIT) && (state_d == L_UP);
        end
    end

endmodule

// File: rtl/bcr_port.sv
module bcr_port
    import bcr_pkg::*;
#(
    parameter int PORT_ID   = 0,
    parameter int NUM_DB    = 32,
    parameter int NUM_MW    = 4,
    parameter int SPAD_CNT  = 16,
    parameter int DB_STRIDE = 8,
    parameter int AW        = 8,
    parameter int MW_IW     = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic             rd,
    input  logic [AW-1:0]    addr,
    input  logic [31:0]      wdata,
    output logic [31:0]      rdata,
    output logic             db_stb,
    output logic [15:0]      db_cnt,
    output logic             db_msix,
    output logic             mw_stb,
    output logic [MW_IW-1:0] mw_idx,
    output logic [63:0]      mw_addr,
    output logic [31:0]      mw_size,
    output logic             link_set
);

    localparam int          SPAD_BASE = W_DB_BASE + NUM_DB;
    localparam logic [31:0] RO_MW1    = 32'(NUM_DB * DB_STRIDE);
    localparam logic [31:0] RO_MWN    = 32'(NUM_MW);
    localparam logic [31:0] RO_SPO    = 32'(SPAD_BASE * 4);
    localparam logic [31:0] RO_SPN    = 32'(SPAD_CNT);
    localparam logic [31:0] RO_STR    = 32'(DB_STRIDE);
    localparam logic [31:0] RO_TOPO   = (PORT_ID == 0) ? TOPO_PRIMARY : TOPO_SECONDARY;

    port_state_t state_q, state_d;
    logic [31:0] cmd_q, arg_q, alo_q, ahi_q, size_q, status_q;
    logic [31:0] db_data_q [NUM_DB];
    logic [31:0] spad_q    [SPAD_CNT];
    logic [31:0] rd_val;
    int          a_idx;
    logic        cmd_start;
    logic        ex_db, ex_mw, ex_link, ex_ok;

    assign a_idx     = int'({{(32-AW){1'b0}}, addr});
    assign cmd_start = wr && (a_idx == W_CMD) && (state_q == P_IDLE) && (wdata != 32'd0);

    // command decode during the execute cycle
    always_comb begin
        ex_db   = 1'b0;
        ex_mw   = 1'b0;
        ex_link = 1'b0;
        if (state_q == P_EXEC) begin
            unique case (cmd_q)
                CMD_DOORBELL: ex_db   = (arg_q[15:0] != 16'd0) && (arg_q[15:0] <= 16'(NUM_DB));
                CMD_WINDOW:   ex_mw   = (arg_q < RO_MWN);
                CMD_LINK:     ex_link = 1'b1;
                default:      ;
            endcase
        end
        ex_ok = ex_db | ex_mw | ex_link;
    end

    assign link_set = ex_link;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            P_IDLE: if (cmd_start) state_d = P_EXEC;
            P_EXEC: state_d = P_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= P_IDLE;
        else        state_q <= state_d;
    end

    // read mux
    always_comb begin
        rd_val = 32'd0;
        case (a_idx)
            W_CMD:     rd_val = cmd_q;
            W_ARG:     rd_val = arg_q;
            W_STATUS:  rd_val = status_q;
            W_TOPO:    rd_val = RO_TOPO;
            W_ADDR_LO: rd_val = alo_q;
            W_ADDR_HI: rd_val = ahi_q;
            W_SIZE:    rd_val = size_q;
            W_MW1_OFF: rd_val = RO_MW1;
            W_MW_NUM:  rd_val = RO_MWN;
            W_SP_OFF:  rd_val = RO_SPO;
            W_SP_NUM:  rd_val = RO_SPN;
            W_DB_STR:  rd_val = RO_STR;
            default:   ;
        endcase
        for (int i = 0; i < NUM_DB; i++)
            if (a_idx == W_DB_BASE + i) rd_val = db_data_q[i];
        for (int i = 0; i < SPAD_CNT; i++)
            if (a_idx == SPAD_BASE + i) rd_val = spad_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q    <= '0;
            arg_q    <= '0;
            alo_q    <= '0;
            ahi_q    <= '0;
            size_q   <= '0;
            status_q <= STS_IDLE;
            rdata    <= '0;
            db_stb   <= 1'b0;
            db_cnt   <= '0;
            db_msix  <= 1'b0;
            mw_stb   <= 1'b0;
            mw_idx   <= '0;
            mw_addr  <= '0;
            mw_size  <= '0;
            for (int i = 0; i < NUM_DB; i++)   db_data_q[i] <= '0;
            for (int i = 0; i < SPAD_CNT; i++) spad_q[i]    <= '0;
        end else begin
            db_stb <= 1'b0;
            mw_stb <= 1'b0;
            if (wr) begin
                if (a_idx == W_ARG)     arg_q  <= wdata;
                if (a_idx == W_ADDR_LO) alo_q  <= wdata;
                if (a_idx == W_ADDR_HI) ahi_q  <= wdata;
                if (a_idx == W_SIZE)    size_q <= wdata;
                for (int i = 0; i < NUM_DB; i++)
                    if (a_idx == W_DB_BASE + i) db_data_q[i] <= wdata;
                for (int i = 0; i < SPAD_CNT; i++)
                    if (a_idx == SPAD_BASE + i) spad_q[i] <= wdata;
            end
            if (cmd_start) begin
                cmd_q    <= wdata;
                status_q <= STS_BUSY;
            end
            if (state_q == P_EXEC) begin
                cmd_q    <= '0;
                status_q <= ex_ok ? STS_OK : STS_ERR;
                if (ex_db) begin
                    db_stb  <= 1'b1;
                    db_cnt  <= arg_q[15:0];
                    db_msix <= arg_q[16];
                end
                if (ex_mw) begin
                    mw_stb  <= 1'b1;
                    mw_idx  <= arg_q[MW_IW-1:0];
                    mw_addr <= {ahi_q, alo_q};
                    mw_size <= size_q;
                end
            end
            if (rd) rdata <= rd_val;
        end
    end

endmodule

// File: rtl/bridge_cmd_regs.sv
module bridge_cmd_regs
    import bcr_pkg::*;
#(
    parameter  int NUM_DB    = 32,
    parameter  int NUM_MW    = 4,
    parameter  int SPAD_CNT  = 16,
    parameter  int DB_STRIDE = 8,
    parameter  int AW        = 8,
    localparam int MW_IW     = (NUM_MW > 1) ? $clog2(NUM_MW) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [1:0]            h_wr,
    input  logic [1:0]            h_rd,
    input  logic [1:0][AW-1:0]    h_addr,
    input  logic [1:0][31:0]      h_wdata,
    output logic [1:0][31:0]      h_rdata,
    output logic [1:0]            db_stb,
    output logic [1:0][15:0]      db_cnt,
    output logic [1:0]            db_msix,
    output logic [1:0]            mw_stb,
    output logic [1:0][MW_IW-1:0] mw_idx,
    output logic [1:0][63:0]      mw_addr,
    output logic [1:0][31:0]      mw_size,
    output logic [1:0]            link_evt
);

    localparam int NPORT = 2;

    logic [NPORT-1:0] link_set;
    logic             evt;

    for (genvar g = 0; g < NPORT; g++) begin : g_port
        bcr_port #(
            .PORT_ID  (g),
            .NUM_DB   (NUM_DB),
            .NUM_MW   (NUM_MW),
            .SPAD_CNT (SPAD_CNT),
            .DB_STRIDE(DB_STRIDE),
            .AW       (AW),
            .MW_IW    (MW_IW)
        ) i_port (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr      (h_wr[g]),
            .rd      (h_rd[g]),
            .addr    (h_addr[g]),
            .wdata   (h_wdata[g]),
            .rdata   (h_rdata[g]),
            .db_stb  (db_stb[g]),
            .db_cnt  (db_cnt[g]),
            .db_msix (db_msix[g]),
            .mw_stb  (mw_stb[g]),
            .mw_idx  (mw_idx[g]),
            .mw_addr (mw_addr[g]),
            .mw_size (mw_size[g]),
            .link_set(link_set[g])
        );
    end

    bcr_link i_link (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_req(link_set),
        .evt    (evt)
    );

    assign link_evt = {NPORT{evt}};

endmodule

// File: rtl/bcr_checker.sv
module bcr_checker #(
    parameter int NUM_DB = 32,
    parameter int NUM_MW = 4,
    parameter int MW_IW  = 2
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [1:0]            db_stb,
    input logic [1:0][15:0]      db_cnt,
    input logic [1:0]            mw_stb,
    input logic [1:0][MW_IW-1:0] mw_idx,
    input logic [1:0][63:0]      mw_addr,
    input logic [1:0][31:0]      mw_size,
    input logic [1:0]            link_evt
);

    logic evt_seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           evt_seen_q <= 1'b0;
        else if (link_evt[0]) evt_seen_q <= 1'b1;
    end

    for (genvar p = 0; p < 2; p++) begin : g_chk
        a_r4_db_count_legal: assert property (@(posedge clk) disable iff (!rst_n)
            db_stb[p] |-> (db_cnt[p] != 16'd0) && (db_cnt[p] <= 16'(NUM_DB)));

        a_r4_db_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
            db_stb[p] |=> !db_stb[p]);

        a_r5_mw_index_legal: assert property (@(posedge clk) disable iff (!rst_n)
            mw_stb[p] |-> (32'(mw_idx[p]) < 32'(NUM_MW)));

        a_r6_one_update: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0({db_stb[p], mw_stb[p]}));

        a_r6_mw_held: assert property (@(posedge clk) disable iff (!rst_n)
            !mw_stb[p] |-> ($stable(mw_addr[p]) && $stable(mw_size[p]) && $stable(mw_idx[p])));

        a_r6_db_held: assert property (@(posedge clk) disable iff (!rst_n)
            !db_stb[p] |-> $stable(db_cnt[p]));
    end

    a_r7_link_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        link_evt[0] |=> !link_evt[0]);

    a_r7_link_once: assert property (@(posedge clk) disable iff (!rst_n)
        link_evt[0] |-> !evt_seen_q);

endmodule

bind bridge_cmd_regs bcr_checker #(
    .NUM_DB(NUM_DB),
    .NUM_MW(NUM_MW),
    .MW_IW (MW_IW)
) i_bcr_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .db_stb  (db_stb),
    .db_cnt  (db_cnt),
    .mw_stb  (mw_stb),
    .mw_idx  (mw_idx),
    .mw_addr (mw_addr),
    .mw_size (mw_size),
    .link_evt(link_evt)
);

// File: tb/test_bridge_cmd_regs.sv
module test_bridge_cmd_regs;

    localparam int CLK_P     = 10;
    localparam int NUM_DB    = 4;
    localparam int NUM_MW    = 3;
    localparam int SPAD_CNT  = 4;
    localparam int DB_STRIDE = 8;
    localparam int AW        = 6;
    localparam int MW_IW     = 2;
    localparam int SP_BASE   = 12 + NUM_DB;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic [1:0]            h_wr = '0;
    logic [1:0]            h_rd = '0;
    logic [1:0][AW-1:0]    h_addr = '0;
    logic [1:0][31:0]      h_wdata = '0;
    logic [1:0][31:0]      h_rdata;
    logic [1:0]            db_stb;
    logic [1:0][15:0]      db_cnt;
    logic [1:0]            db_msix;
    logic [1:0]            mw_stb;
    logic [1:0][MW_IW-1:0] mw_idx;
    logic [1:0][63:0]      mw_addr;
    logic [1:0][31:0]      mw_size;
    logic [1:0]            link_evt;

    int n_cmp = 0;
    int n_bad = 0;

    // bench model
    logic [31:0] m_arg [2];
    logic [31:0] m_alo [2];
    logic [31:0] m_ahi [2];
    logic [31:0] m_size[2];
    logic [15:0] m_dbc [2];
    logic        m_msx [2];
    logic [MW_IW-1:0] m_idx[2];
    logic [63:0] m_mwa [2];
    logic [31:0] m_mws [2];
    logic [31:0] m_sts [2];
    logic [31:0] m_dbd [2][NUM_DB];
    logic [31:0] m_sp  [2][SPAD_CNT];
    logic        m_rdy [2];
    logic        m_done;

    always #(CLK_P/2) clk = ~clk;

    bridge_cmd_regs #(
        .NUM_DB(NUM_DB), .NUM_MW(NUM_MW), .SPAD_CNT(SPAD_CNT),
        .DB_STRIDE(DB_STRIDE), .AW(AW)
    ) i_bridge_cmd_regs (
        .clk(clk), .rst_n(rst_n), .h_wr(h_wr), .h_rd(h_rd), .h_addr(h_addr),
        .h_wdata(h_wdata), .h_rdata(h_rdata), .db_stb(db_stb), .db_cnt(db_cnt),
        .db_msix(db_msix), .mw_stb(mw_stb), .mw_idx(mw_idx), .mw_addr(mw_addr),
        .mw_size(mw_size), .link_evt(link_evt)
    );

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] ro_value(int p, int a);
        case (a)
            3:  return (p == 0) ? 32'd1 : 32'd2;
            7:  return 32'(NUM_DB * DB_STRIDE);
            8:  return 32'(NUM_MW);
            9:  return 32'(SP_BASE * 4);
            10: return 32'(SPAD_CNT);
            11: return 32'(DB_STRIDE);
            default: return 32'd0;
        endcase
    endfunction

    task automatic wr(int p, int a, logic [31:0] d);
        @(negedge clk);
        h_wr[p]    = 1'b1;
        h_addr[p]  = AW'(a);
        h_wdata[p] = d;
        @(posedge clk);
        #1;
        h_wr[p] = 1'b0;
    endtask

    task automatic rd(int p, int a, output logic [31:0] d);
        @(negedge clk);
        h_rd[p]   = 1'b1;
        h_addr[p] = AW'(a);
        @(posedge clk);
        #1;
        d = h_rdata[p];
        h_rd[p] = 1'b0;
    endtask

    // writes a data word and tracks it in the model
    task automatic put(int p, int a, logic [31:0] d);
        wr(p, a, d);
        if (a == 1) m_arg[p]  = d;
        if (a == 4) m_alo[p]  = d;
        if (a == 5) m_ahi[p]  = d;
        if (a == 6) m_size[p] = d;
        if (a >= 12 && a < SP_BASE) m_dbd[p][a-12] = d;
        if (a >= SP_BASE && a < SP_BASE + SPAD_CNT) m_sp[p][a-SP_BASE] = d;
    endtask

    task automatic check_cfg(int p, string req);
        chk(req, "db_cnt", 64'(db_cnt[p]), 64'(m_dbc[p]));
        chk(req, "db_msix", 64'(db_msix[p]), 64'(m_msx[p]));
        chk(req, "mw_idx", 64'(mw_idx[p]), 64'(m_idx[p]));
        chk(req, "mw_addr", mw_addr[p], m_mwa[p]);
        chk(req, "mw_size", 64'(mw_size[p]), 64'(m_mws[p]));
    endtask

    task automatic issue(int p, logic [31:0] cmd);
        logic ok, isdb, ismw, evt;
        logic [31:0] d;
        isdb = (cmd == 32'd1) && (m_arg[p][15:0] != 0) && (m_arg[p][15:0] <= 16'(NUM_DB));
        ismw = (cmd == 32'd2) && (m_arg[p] < 32'(NUM_MW));
        ok   = isdb || ismw || (cmd == 32'd3);
        wr(p, 0, cmd);
        @(posedge clk);
        #1;
        if (isdb) begin
            m_dbc[p] = m_arg[p][15:0];
            m_msx[p] = m_arg[p][16];
        end
        if (ismw) begin
            m_idx[p] = m_arg[p][MW_IW-1:0];
            m_mwa[p] = {m_ahi[p], m_alo[p]};
            m_mws[p] = m_size[p];
        end
        chk("R4", "db_stb", 64'(db_stb[p]), 64'(isdb));
        chk("R5", "mw_stb", 64'(mw_stb[p]), 64'(ismw));
        check_cfg(p, ok ? "R5" : "R6");
        evt = 1'b0;
        if (cmd == 32'd3) begin
            m_rdy[p] = 1'b1;
            evt = m_rdy[0] && m_rdy[1] && !m_done;
            if (evt) m_done = 1'b1;
        end
        @(posedge clk);
        #1;
        chk("R7", "link_evt", 64'(link_evt), evt ? 64'd3 : 64'd0);
        m_sts[p] = ok ? 32'd2 : 32'd3;
        rd(p, 2, d);
        chk("R3", "status", 64'(d), 64'(m_sts[p]));
        rd(p, 0, d);
        chk("R3", "cmd cleared", 64'(d), 64'd0);
    endtask

    initial begin
        #(CLK_P * 150000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd20240611));
        for (int p = 0; p < 2; p++) begin
            m_arg[p] = 0; m_alo[p] = 0; m_ahi[p] = 0; m_size[p] = 0;
            m_dbc[p] = 0; m_msx[p] = 0; m_idx[p] = 0; m_mwa[p] = 0; m_mws[p] = 0;
            m_sts[p] = 0; m_rdy[p] = 0;
            for (int i = 0; i < NUM_DB; i++) m_dbd[p][i] = 0;
            for (int i = 0; i < SPAD_CNT; i++) m_sp[p][i] = 0;
        end
        m_done = 1'b0;

        // R9 reset state
        repeat (3) @(posedge clk);
        #1;
        chk("R9", "db_stb", 64'(db_stb), 64'd0);
        chk("R9", "mw_stb", 64'(mw_stb), 64'd0);
        chk("R9", "link_evt", 64'(link_evt), 64'd0);
        for (int p = 0; p < 2; p++) check_cfg(p, "R9");
        @(negedge clk);
        rst_n = 1'b1;
        for (int p = 0; p < 2; p++) begin
            rd(p, 2, d); chk("R9", "status", 64'(d), 64'd0);
            rd(p, 0, d); chk("R9", "cmd", 64'(d), 64'd0);
        end

        // R1, R2 read-only words and unmapped words
        for (int p = 0; p < 2; p++) begin
            for (int a = 7; a <= 11; a++) begin
                rd(p, a, d); chk("R2", "ro word", 64'(d), 64'(ro_value(p, a)));
            end
            rd(p, 3, d); chk("R2", "topology", 64'(d), 64'(ro_value(p, 3)));
            wr(p, 3, 32'hFFFF_FFFF);
            wr(p, 9, 32'h1234_5678);
            wr(p, 2, 32'h0000_00AA);
            rd(p, 3, d); chk("R2", "topology after write", 64'(d), 64'(ro_value(p, 3)));
            rd(p, 9, d); chk("R2", "spad offset after write", 64'(d), 64'(ro_value(p, 9)));
            rd(p, 2, d); chk("R2", "status after write", 64'(d), 64'd0);
            for (int a = SP_BASE + SPAD_CNT; a < 64; a += 7) begin
                wr(p, a, 32'hDEAD_BEEF);
                rd(p, a, d); chk("R1", "unmapped", 64'(d), 64'd0);
            end
        end

        // R3 busy then error, zero write ignored
        wr(0, 0, 32'd9);
        rd(0, 2, d); chk("R3", "busy", 64'(d), 64'd1);
        rd(0, 2, d); chk("R3", "error done", 64'(d), 64'd3);
        rd(0, 0, d); chk("R3", "cmd cleared", 64'(d), 64'd0);
        m_sts[0] = 32'd3;
        wr(0, 0, 32'd0);
        @(posedge clk);
        #1;
        rd(0, 2, d); chk("R3", "zero cmd no effect", 64'(d), 64'd3);
        check_cfg(0, "R6");

        // R4 doorbell boundaries
        put(0, 1, 32'h0001_0004); issue(0, 32'd1);
        put(0, 1, 32'h0000_0005); issue(0, 32'd1);
        put(0, 1, 32'h0001_0000); issue(0, 32'd1);
        put(1, 1, 32'h0000_0001); issue(1, 32'd1);

        // R5 window boundaries
        put(1, 4, 32'h8000_1000); put(1, 5, 32'h0000_00F0); put(1, 6, 32'h0010_0000);
        put(1, 1, 32'd2); issue(1, 32'd2);
        put(1, 4, 32'h1111_2222); put(1, 1, 32'd3); issue(1, 32'd2);
        put(0, 1, 32'd0); issue(0, 32'd2);

        // R7 link handshake
        issue(0, 32'd3);
        issue(0, 32'd3);
        issue(1, 32'd3);
        issue(1, 32'd3);
        issue(0, 32'd3);

        // R8 independence of the banks
        put(0, SP_BASE, 32'hA5A5_0000);
        put(1, SP_BASE, 32'h5A5A_1111);
        put(0, 12 + NUM_DB - 1, 32'hC0DE_0001);
        rd(0, SP_BASE, d); chk("R8", "spad p0", 64'(d), 64'(m_sp[0][0]));
        rd(1, SP_BASE, d); chk("R8", "spad p1", 64'(d), 64'(m_sp[1][0]));
        rd(1, 12 + NUM_DB - 1, d); chk("R8", "db data p1", 64'(d), 64'(m_dbd[1][NUM_DB-1]));

        // constrained random mix
        for (int it = 0; it < 400; it++) begin
            int p, op, a;
            p  = int'($urandom_range(0, 1));
            op = int'($urandom_range(0, 5));
            case (op)
                0: begin
                    a = SP_BASE + int'($urandom_range(0, SPAD_CNT - 1));
                    put(p, a, $urandom());
                    a = SP_BASE + int'($urandom_range(0, SPAD_CNT - 1));
                    rd(1 - p, a, d);
                    chk("R8", "spad rand", 64'(d), 64'(m_sp[1-p][a-SP_BASE]));
                end
                1: begin
                    a = 12 + int'($urandom_range(0, NUM_DB - 1));
                    put(p, a, $urandom());
                    rd(p, a, d);
                    chk("R8", "db data rand", 64'(d), 64'(m_dbd[p][a-12]));
                end
                2: begin
                    put(p, 1, {$urandom_range(0, 32767), 1'($urandom()),
                               16'($urandom_range(0, NUM_DB + 1))});
                    issue(p, 32'd1);
                end
                3: begin
                    put(p, 4, $urandom());
                    put(p, 5, $urandom());
                    put(p, 6, $urandom());
                    if ($urandom_range(0, 7) == 0) put(p, 1, 32'h0001_0000);
                    else put(p, 1, 32'($urandom_range(0, NUM_MW)));
                    issue(p, 32'd2);
                end
                4: begin
                    if ($urandom_range(0, 1) == 0) issue(p, 32'd3);
                    else issue(p, 32'($urandom_range(4, 255)));
                end
                default: begin
                    a = int'($urandom_range(0, 63));
                    if (a == 3 || (a >= 7 && a <= 11)) begin
                        rd(p, a, d);
                        chk("R2", "ro rand", 64'(d), 64'(ro_value(p, a)));
                    end else if (a >= SP_BASE + SPAD_CNT) begin
                        rd(p, a, d);
                        chk("R1", "unmapped rand", 64'(d), 64'd0);
                    end else begin
                        rd(p, 2, d);
                        chk("R3", "status rand", 64'(d), 64'(m_sts[p]));
                    end
                end
            endcase
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule